// File: doc/BRIEF.md
# Increment/Add Unit with Status Flags

This block is a small integer datapath with a six-bit status register. On each cycle where the valid strobe is high, it takes an operation code and two operands, A and B. It computes a result from them and registers that result. It also updates the zero, sign, overflow, carry, auxiliary-carry and parity flags.

Each operation follows its own rule about which flags it writes and which flags keep their stored value. For example, an increment leaves the carry flag alone, and a bitwise NOT touches no flag at all. A surrounding core can therefore chain an increment after an add without losing the add's carry.

The operand width is a parameter and defaults to 16 bits. The width must be at least 8, because parity is taken over the low byte of the result and auxiliary carry is taken at bit 3.

Top module: `incflag_unit`

## Requirements
- R1: With op code 0 (increment), the result becomes A+1 modulo 2^W. Zero, sign, overflow, auxiliary-carry and parity are written. Carry keeps its previous value. Overflow is set only when A is the largest positive signed value, and an all-ones A gives a zero result with the zero flag set.
- R2: With op code 1 (add), the result becomes A+B modulo 2^W and all six flags are written. Carry is the unsigned carry out of the top bit. Overflow is set when both operands share a sign and the result's sign differs from it.
- R3: For increment and add, auxiliary carry is set when the low four bits produce a carry into bit 4. Every other op code leaves auxiliary carry unchanged.
- R4: Whenever an operation writes parity, parity is 1 exactly when the low 8 bits of the result hold an even number of ones. Zero is set when the whole result is 0, and sign equals the result's MSB.
- R5: Op codes 2, 3 and 4 (AND, OR, XOR of A and B) write the result and the zero, sign and parity flags. They clear carry and overflow.
- R6: Op code 5 (NOT) writes the result as the inverse of A and leaves all six flags unchanged.
- R7: Op code 6 (shift left) moves A's MSB into carry and shifts in a 0. Op code 7 (logical shift right) moves A's LSB into carry and shifts in a 0. Op code 8 (arithmetic shift right) moves A's LSB into carry and copies the old MSB back into the MSB. All three write zero, sign and parity, and keep overflow.
- R8: Op code 9 (rotate left) copies A's MSB into both carry and bit 0. Op code 10 (rotate right) copies A's LSB into both carry and the MSB. Rotates write only the result and carry.
- R9: When valid is low, or when the op code is 11 to 15, the result and all flags keep their values.
- R10: A synchronous active-low reset clears the result and all six flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation selector (0..10 defined) |
| opnd_a | input | DATA_W | Operand A |
| opnd_b | input | DATA_W | Operand B |
| result_q | output | DATA_W | Registered result |
| zero_q | output | 1 | Zero flag |
| sign_q | output | 1 | Sign flag |
| ovf_q | output | 1 | Overflow flag |
| carry_q | output | 1 | Carry flag |
| aux_q | output | 1 | Auxiliary-carry flag |
| par_q | output | 1 | Parity flag |

## Verification
The assertions check the following on every cycle:
- Carry is preserved across an increment.
- NOT leaves every flag untouched.
- The logical operations clear carry and overflow.
- Auxiliary carry holds its value outside increment and add.
- Idle cycles hold all state.
- Zero and parity agree with the stored result after any operation that writes them.
- The reset values are correct.

Other properties need the bench's reference model and its scenarios:
- The arithmetic values themselves, including signed overflow at the positive limit and wrap from all-ones.
- The exact bit that shifts and rotates move into carry and into the vacated position.
- The rule that an increment placed after an add keeps the add's carry.

// File: rtl/incflag_pkg.sv
`timescale 1ns/1ps
// Shared types for the increment/add flag unit.
// Assumes a 4-bit operation code; codes 11..15 are unused.
package incflag_pkg;
    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_INC = 4'd0,
        OPC_ADD = 4'd1,
        OPC_AND = 4'd2,
        OPC_OR  = 4'd3,
        OPC_XOR = 4'd4,
        OPC_NOT = 4'd5,
        OPC_SHL = 4'd6,
        OPC_SHR = 4'd7,
        OPC_SAR = 4'd8,
        OPC_ROL = 4'd9,
        OPC_ROR = 4'd10
    } opc_e;

    // One status bit per flag; the same layout also serves as a write mask.
    typedef struct packed {
        logic z;
        logic s;
        logic o;
        logic c;
        logic a;
        logic p;
    } flag_s;
endpackage

// File: rtl/incadd_unit.sv
`timescale 1ns/1ps
// Adder shared by increment and add. When use_one is set, B is replaced by 1.
// Produces the sum, the unsigned carry out, the signed overflow and the
// carry into bit 4. Assumes DATA_W >= 8.
module incadd_unit #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              use_one,
    output logic [DATA_W-1:0] sum_out,
    output logic              cout,
    output logic              ovf,
    output logic              aux
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] addend;
    logic [DATA_W:0]   full;

    // Pick the second operand and form the wide sum.
    always_comb begin
        addend  = use_one ? {{(DATA_W-1){1'b0}}, 1'b1} : b_in;
        full    = {1'b0, a_in} + {1'b0, addend};
        sum_out = full[MSB:0];
        cout    = full[DATA_W];
        ovf     = (a_in[MSB] == addend[MSB]) && (sum_out[MSB] != a_in[MSB]);
        aux     = a_in[4] ^ addend[4] ^ sum_out[4];
    end
endmodule

// File: rtl/bitlogic_unit.sv
`timescale 1ns/1ps
// Bitwise operations: sel 0 = AND, 1 = OR, 2 = XOR, 3 = NOT of A.
module bitlogic_unit #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] res_out
);
    // Select the bitwise function.
    always_comb begin
        unique case (sel)
            2'd0:    res_out = a_in & b_in;
            2'd1:    res_out = a_in | b_in;
            2'd2:    res_out = a_in ^ b_in;
            default: res_out = ~a_in;
        endcase
    end
endmodule

// File: rtl/shift_unit.sv
`timescale 1ns/1ps
// One-bit shifts and rotates of A. The sel encoding is:
// 0 = shift left, 1 = logical shift right, 2 = arithmetic shift right,
// 3 = rotate left, 4 = rotate right.
// out_bit is the bit that leaves the operand, which becomes the new carry.
module shift_unit #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [2:0]        sel,
    output logic [DATA_W-1:0] res_out,
    output logic              out_bit
);
    localparam int MSB = DATA_W - 1;

    // Form the shifted word and the departing bit.
    always_comb begin
        unique case (sel)
            3'd0:    begin res_out = {a_in[MSB-1:0], 1'b0};      out_bit = a_in[MSB]; end
            3'd1:    begin res_out = {1'b0, a_in[MSB:1]};        out_bit = a_in[0];   end
            3'd2:    begin res_out = {a_in[MSB], a_in[MSB:1]};   out_bit = a_in[0];   end
            3'd3:    begin res_out = {a_in[MSB-1:0], a_in[MSB]}; out_bit = a_in[MSB]; end
            default: begin res_out = {a_in[0], a_in[MSB:1]};     out_bit = a_in[0];   end
        endcase
    end
endmodule

// File: rtl/incflag_unit.sv
`timescale 1ns/1ps
// Top of the increment/add unit. It decodes the op code, selects a result
// from the three sub-units, builds the flag values and a per-operation write
// mask, and registers result and flags on valid cycles with a known op code.
// Assumes DATA_W >= 8 (parity uses the low byte, aux carry uses bit 4).
module incflag_unit
    import incflag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result_q,
    output logic              zero_q,
    output logic              sign_q,
    output logic              ovf_q,
    output logic              carry_q,
    output logic              aux_q,
    output logic              par_q
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] add_sum, log_res, sh_res, nxt_res;
    logic              add_cout, add_ovf, add_aux, sh_bit;
    logic [1:0]        log_sel;
    logic [2:0]        sh_sel;
    logic              use_one, op_known;
    flag_s             cur_f, new_f, wr_f, nxt_f;

    incadd_unit #(.DATA_W(DATA_W)) u_add (
        .a_in(opnd_a), .b_in(opnd_b), .use_one(use_one),
        .sum_out(add_sum), .cout(add_cout), .ovf(add_ovf), .aux(add_aux)
    );

    bitlogic_unit #(.DATA_W(DATA_W)) u_log (
        .a_in(opnd_a), .b_in(opnd_b), .sel(log_sel), .res_out(log_res)
    );

    shift_unit #(.DATA_W(DATA_W)) u_sh (
        .a_in(opnd_a), .sel(sh_sel), .res_out(sh_res), .out_bit(sh_bit)
    );

    // Derive the sub-unit selectors from the op code.
    always_comb begin
        use_one = (op_code == OPC_INC);
        log_sel = 2'(op_code - OPC_AND);
        sh_sel  = 3'(op_code - OPC_SHL);
    end

    // Pick the result, the candidate flag values and the write mask.
    always_comb begin
        cur_f    = '{z: zero_q, s: sign_q, o: ovf_q, c: carry_q, a: aux_q, p: par_q};
        nxt_res  = result_q;
        wr_f     = '0;
        op_known = 1'b1;
        new_f    = '0;
        unique case (op_code)
            OPC_INC: begin nxt_res = add_sum; wr_f = '{z:1, s:1, o:1, c:0, a:1, p:1}; end
            OPC_ADD: begin nxt_res = add_sum; wr_f = '{z:1, s:1, o:1, c:1, a:1, p:1}; end
            OPC_AND, OPC_OR, OPC_XOR:
                     begin nxt_res = log_res; wr_f = '{z:1, s:1, o:1, c:1, a:0, p:1}; end
            OPC_NOT: begin nxt_res = log_res; wr_f = '0; end
            OPC_SHL, OPC_SHR, OPC_SAR:
                     begin nxt_res = sh_res;  wr_f = '{z:1, s:1, o:0, c:1, a:0, p:1}; end
            OPC_ROL, OPC_ROR:
                     begin nxt_res = sh_res;  wr_f = '{z:0, s:0, o:0, c:1, a:0, p:0}; end
            default: op_known = 1'b0;
        endcase
        new_f.z = (nxt_res == '0);
        new_f.s = nxt_res[MSB];
        new_f.p = ~^nxt_res[7:0];
        new_f.a = add_aux;
        new_f.o = (op_code == OPC_INC || op_code == OPC_ADD) ? add_ovf : 1'b0;
        new_f.c = (op_code == OPC_ADD) ? add_cout :
                  (op_code >= OPC_SHL) ? sh_bit : 1'b0;
        nxt_f   = (new_f & wr_f) | (cur_f & ~wr_f);
    end

    // Register result and flags; hold on idle cycles and unused op codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            {zero_q, sign_q, ovf_q, carry_q, aux_q, par_q} <= '0;
        end else if (op_valid && op_known) begin
            result_q <= nxt_res;
            {zero_q, sign_q, ovf_q, carry_q, aux_q, par_q} <= nxt_f;
        end
    end
endmodule

// File: rtl/incflag_checker.sv
`timescale 1ns/1ps
// Property checker for incflag_unit, attached by bind. It observes ports only.
module incflag_checker
    import incflag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OPC_W-1:0]  op_code,
    input logic [DATA_W-1:0] result_q,
    input logic              zero_q,
    input logic              sign_q,
    input logic              ovf_q,
    input logic              carry_q,
    input logic              aux_q,
    input logic              par_q
);
    logic [5:0] flags;
    logic       is_logic, is_arith, writes_zp;

    // Group the flags and classify the current op code.
    always_comb begin
        flags     = {zero_q, sign_q, ovf_q, carry_q, aux_q, par_q};
        is_logic  = op_code == OPC_AND || op_code == OPC_OR || op_code == OPC_XOR;
        is_arith  = op_code == OPC_INC || op_code == OPC_ADD;
        writes_zp = is_arith || is_logic || op_code == OPC_SHL ||
                    op_code == OPC_SHR || op_code == OPC_SAR;
    end

    a_r1_inc_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OPC_INC |=> carry_q == $past(carry_q));

    a_r3_aux_held: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !is_arith |=> aux_q == $past(aux_q));

    a_r4_zero_parity: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && writes_zp |=> zero_q == (result_q == '0) && par_q == ~^result_q[7:0]);

    a_r5_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && is_logic |=> !carry_q && !ovf_q);

    a_r6_not_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OPC_NOT |=> $stable(flags));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags) && $stable(result_q));

    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> flags == '0 && result_q == '0);
endmodule

bind incflag_unit incflag_checker #(.DATA_W(DATA_W)) u_incflag_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .result_q(result_q), .zero_q(zero_q), .sign_q(sign_q), .ovf_q(ovf_q),
    .carry_q(carry_q), .aux_q(aux_q), .par_q(par_q)
);

// File: tb/test_incflag_unit.sv
`timescale 1ns/1ps
// Bench for incflag_unit: directed corner cases plus seeded random stimulus,
// compared with a reference model written from the requirements.
module test_incflag_unit;
    localparam int W = 16;
    localparam int SV_W = W + 6;   // {result, z, s, o, c, a, p}

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic [W-1:0] result_q;
    logic         zero_q, sign_q, ovf_q, carry_q, aux_q, par_q;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [SV_W-1:0] model_st = '0;

    always #2 clk = ~clk;

    incflag_unit #(.DATA_W(W)) i_incflag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result_q(result_q),
        .zero_q(zero_q), .sign_q(sign_q), .ovf_q(ovf_q), .carry_q(carry_q),
        .aux_q(aux_q), .par_q(par_q)
    );

    // Reference next state computed from the requirements.
    function automatic logic [SV_W-1:0] ref_next(input logic v, input logic [3:0] op,
            input logic [W-1:0] a, input logic [W-1:0] b, input logic [SV_W-1:0] st);
        logic [W-1:0] r;
        logic z, s, o, c, x, p, zsp;
        logic [W:0] wide;
        {r, z, s, o, c, x, p} = st;
        if (!v || op > 4'd10) return st;
        zsp = 1'b1;
        case (op)
            4'd0: begin r = a + 1'b1; o = (a == {1'b0, {(W-1){1'b1}}}); x = (a[3:0] == 4'hF); end
            4'd1: begin
                wide = a + b; r = wide[W-1:0]; c = wide[W];
                o = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
                x = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
            end
            4'd2: begin r = a & b; c = 0; o = 0; end
            4'd3: begin r = a | b; c = 0; o = 0; end
            4'd4: begin r = a ^ b; c = 0; o = 0; end
            4'd5: begin r = ~a; zsp = 0; end
            4'd6: begin r = a << 1; c = a[W-1]; end
            4'd7: begin r = a >> 1; c = a[0]; end
            4'd8: begin r = {a[W-1], a[W-1:1]}; c = a[0]; end
            4'd9: begin r = {a[W-2:0], a[W-1]}; c = a[W-1]; zsp = 0; end
            default: begin r = {a[0], a[W-1:1]}; c = a[0]; zsp = 0; end
        endcase
        if (zsp) begin
            z = (r == 0); s = r[W-1]; p = ($countones(r[7:0]) % 2) == 0;
        end
        return {r, z, s, o, c, x, p};
    endfunction

    function automatic string req_of(input logic v, input logic [3:0] op);
        if (!v || op > 4'd10) return "R9";
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R5";
            4'd5: return "R6";
            4'd6, 4'd7, 4'd8: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [SV_W-1:0] got;
        got = {result_q, zero_q, sign_q, ovf_q, carry_q, aux_q, par_q};
        n_cmp++;
        if (got !== model_st) begin
            n_bad++;
            $display("FAIL %s: got res=%h zsocap=%b expected res=%h zsocap=%b",
                     tag, got[SV_W-1:6], got[5:0], model_st[SV_W-1:6], model_st[5:0]);
        end
    endtask

    // Drive one cycle at the falling edge, then check one edge later.
    task automatic step(input logic v, input logic [3:0] op,
                        input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        model_st = ref_next(v, op, a, b, model_st);
        compare(tag);
    endtask

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        @(negedge clk); @(negedge clk);
        model_st = '0;
        compare("R10 reset");
        rst_n = 1'b1;
        // R1: positive limit overflows; all-ones wraps to zero; carry kept from ADD.
        step(1, 4'd1, 16'hFFFF, 16'h0001, "R2 add carry out");
        step(1, 4'd0, 16'h7FFF, 16'h0000, "R1 inc overflow, carry kept");
        step(1, 4'd0, 16'hFFFF, 16'h0000, "R1 inc wrap to zero");
        step(1, 4'd0, 16'h000F, 16'h0000, "R3 inc aux carry");
        step(1, 4'd1, 16'h4000, 16'h4000, "R2 add signed overflow");
        step(1, 4'd1, 16'h0008, 16'h0008, "R3 add aux carry");
        step(1, 4'd2, 16'hF0F0, 16'h0F0F, "R5 and to zero");
        step(1, 4'd4, 16'h8003, 16'h0000, "R4 parity low byte");
        step(1, 4'd5, 16'h1234, 16'h0000, "R6 not keeps flags");
        step(1, 4'd6, 16'h8001, 16'h0000, "R7 shl msb to carry");
        step(1, 4'd8, 16'h8002, 16'h0000, "R7 sar sign fill");
        step(1, 4'd7, 16'h8001, 16'h0000, "R7 shr lsb to carry");
        step(1, 4'd9, 16'h8000, 16'h0000, "R8 rol");
        step(1, 4'd10, 16'h0001, 16'h0000, "R8 ror");
        step(0, 4'd1, 16'hFFFF, 16'hFFFF, "R9 idle hold");
        step(1, 4'd13, 16'h0000, 16'h0000, "R9 unused op");
        for (int i = 0; i < 4000; i++) begin
            logic v;
            logic [3:0] op;
            logic [W-1:0] a, b;
            v  = ($urandom % 8) != 0;
            op = 4'($urandom % 16);
            a  = W'($urandom);
            b  = W'($urandom);
            if (($urandom % 4) == 0) a = {1'b0, {(W-1){1'b1}}} ^ W'($urandom % 2);
            step(v, op, a, b, req_of(v, op));
        end
        rst_n = 1'b0; op_valid = 1'b1; op_code = 4'd1;
        @(negedge clk);
        model_st = '0;
        compare("R10 reset mid-run");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule